// File: doc/BRIEF.md
# Byte-Wide Parallel Flash Command Controller

This block is a synthesizable model of the control side of a byte-wide parallel NOR-style flash. It has a 17-bit address, an 8-bit data bus and three active-low strobes: chip select, output enable and write enable. The host never writes the array directly. Its write strobes feed a small command decoder, and the decoder starts one of two embedded algorithms. The first programs a single byte. The second erases one sector in three steps: every byte in the sector that is not already zero is first cleared to zero, then a timed erase pulse runs, then the whole sector is filled with ones and verified. Each step is timed by a parameterized cycle counter, not by analog pulses.

While an algorithm runs, a read returns status instead of array data. Bit 7 polls the data and bit 6 toggles on each read. When the algorithm ends, the block returns to array reads and accepts the next command. Each of the eight sectors has a protection input that blocks both program and erase. A low-supply input blocks every write strobe. The storage is a behavioural memory. Each sector keeps 2^BYTE_AW bytes, indexed by the low address bits, so the address bits between the byte index and the sector field alias.

Top module: `flash_ctrl`

## Requirements
- R1: `dq_oe_o` is 1 exactly when `ce_ni` and `oe_ni` are both 0, and 0 for every other combination.
- R2: After reset every byte reads 0xFF. In read mode, `dq_o` shows the byte selected by sector field `addr_i[16:14]` and byte index `addr_i[7:0]`, and the array is never written.
- R3: The writes data 0x5A, then data 0x3C, then (address, value) program that byte. The byte then holds its old contents AND value, because programming only clears bits.
- R4: While busy, `dq_o[7]` reads as the complement of bit 7 of the program value during a program, and as 0 during an erase. `dq_o[5:0]` reads 0 while busy.
- R5: While busy, `dq_o[6]` inverts on every read strobe. A read strobe is a falling edge of `oe_ni` while `ce_ni` is 0.
- R6: A program is busy from the edge that accepts its last write until PROG_CYC+1 cycles later. After that, reads return array data and a new command is accepted.
- R7: The writes data 0x5A, then data 0xC3, then data 0x96 at any address in a sector, erase that sector. Afterwards every byte of that sector reads 0xFF, and all other sectors are unchanged.
- R8: An erase clears every non-zero byte of its sector at PRE_CYC cycles per byte before the ERASE_CYC erase pulse. An erase of a sector that holds no zero byte is therefore busy for at least 2^BYTE_AW*PRE_CYC+ERASE_CYC cycles.
- R9: When `prot_i[s]` is 1, a program or erase aimed at sector s returns to read mode at once, and the array is unchanged.
- R10: While `low_vcc_i` is 1, write strobes are ignored and the command state does not advance.
- R11: A second write that is neither 0x3C nor 0xC3, or an erase confirm that is not 0x96, returns the decoder to read mode, and the array is unchanged. A write strobe is a rising edge of `we_ni` while `ce_ni` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 17 | Byte address |
| dq_i | input | 8 | Data written by the host |
| dq_o | output | 8 | Array data, or status while busy |
| dq_oe_o | output | 1 | Output-enable for the bidirectional data bus |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| low_vcc_i | input | 1 | Low-supply indication, blocks writes |
| prot_i | input | 8 | Protection bit for each sector |

## Verification
A write strobe takes effect on the first rising clock edge after `we_ni` goes high. The busy status is visible half a cycle later. The bench drives every input on the falling edge and keeps `we_ni` high for a cycle before it reads. The toggle bit flips on the clock edge that follows the fall of `oe_ni`. Each read therefore holds `oe_ni` low for a full cycle and samples on the next falling edge. The length of an algorithm is not counted cycle by cycle. The bench polls until two reads in a row agree, and it checks the elapsed cycle count against the bounds in R6 and R8.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_KEY, S_PARG, S_ECNF,
    S_PROG, S_PVER, S_PRE, S_ERASE, S_FILL, S_EVER
  } fsm_state_t;

  localparam logic [7:0] CMD_KEY   = 8'h5A;
  localparam logic [7:0] CMD_PROG  = 8'h3C;
  localparam logic [7:0] CMD_ERASE = 8'hC3;
  localparam logic [7:0] CMD_CONF  = 8'h96;
endpackage

// File: rtl/flash_bus_sync.sv
module flash_bus_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  output logic wr_evt_o,
  output logic rd_evt_o
);
  logic we_d, oe_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_d <= 1'b1;
      oe_d <= 1'b1;
    end else begin
      we_d <= we_ni;
      oe_d <= oe_ni;
    end
  end

  // write on we rising edge, read on oe falling edge, both gated by ce
  assign wr_evt_o = !we_d && we_ni && !ce_ni;
  assign rd_evt_o = oe_d && !oe_ni && !ce_ni;
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int SEC_W   = 3,
  parameter int BYTE_AW = 8,
  localparam int IDX_W  = SEC_W + BYTE_AW,
  localparam int DEPTH  = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [7:0]       wdata_i,
  input  logic [IDX_W-1:0] host_raddr_i,
  output logic [7:0]       host_rdata_o,
  input  logic [IDX_W-1:0] alg_raddr_i,
  output logic [7:0]       alg_rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign host_rdata_o = mem[host_raddr_i];
  assign alg_rdata_o  = mem[alg_raddr_i];
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_pkg::*;
#(
  parameter int SEC_W     = 3,
  parameter int BYTE_AW   = 8,
  parameter int PROG_CYC  = 8,
  parameter int PRE_CYC   = 2,
  parameter int ERASE_CYC = 20,
  localparam int IDX_W    = SEC_W + BYTE_AW,
  localparam int NSEC     = 1 << SEC_W,
  localparam int MAXC     = (PROG_CYC > PRE_CYC) ?
                            ((PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC) :
                            ((PRE_CYC > ERASE_CYC) ? PRE_CYC : ERASE_CYC),
  localparam int CNT_W    = $clog2(MAXC + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_evt_i,
  input  logic               rd_evt_i,
  input  logic [SEC_W-1:0]   sec_i,
  input  logic [BYTE_AW-1:0] byte_i,
  input  logic [7:0]         din_i,
  input  logic               low_vcc_i,
  input  logic [NSEC-1:0]    prot_i,
  input  logic [7:0]         mem_rdata_i,
  output logic               mem_we_o,
  output logic [IDX_W-1:0]   mem_addr_o,
  output logic [7:0]         mem_wdata_o,
  output logic               busy_o,
  output logic [7:0]         stat_o
);
  fsm_state_t         st;
  logic [SEC_W-1:0]   op_sec;
  logic [BYTE_AW-1:0] op_byte;
  logic [7:0]         op_data, prog_exp;
  logic [CNT_W-1:0]   cnt;
  logic               tog;
  logic               acc, erasing, last_byte;

  assign acc       = wr_evt_i && !low_vcc_i;
  assign erasing   = st inside {S_PRE, S_ERASE, S_FILL, S_EVER};
  assign busy_o    = erasing || st inside {S_PROG, S_PVER};
  assign last_byte = &op_byte;
  assign mem_addr_o = {op_sec, op_byte};

  always_comb begin
    mem_we_o    = 1'b0;
    mem_wdata_o = 8'h00;
    case (st)
      S_PROG:  if (cnt == CNT_W'(PROG_CYC - 1)) begin
                 mem_we_o    = 1'b1;
                 mem_wdata_o = op_data & mem_rdata_i;
               end
      S_PRE:   if (mem_rdata_i != 8'h00 && cnt == CNT_W'(PRE_CYC - 1)) begin
                 mem_we_o    = 1'b1;
                 mem_wdata_o = 8'h00;
               end
      S_FILL:  begin
                 mem_we_o    = 1'b1;
                 mem_wdata_o = 8'hFF;
               end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= S_IDLE;
      op_sec   <= '0;
      op_byte  <= '0;
      op_data  <= '0;
      prog_exp <= '0;
      cnt      <= '0;
    end else begin
      case (st)
        S_IDLE: if (acc && din_i == CMD_KEY) st <= S_KEY;
        S_KEY:  if (acc) begin
                  if (din_i == CMD_PROG)       st <= S_PARG;
                  else if (din_i == CMD_ERASE) st <= S_ECNF;
                  else                         st <= S_IDLE;
                end
        S_PARG: if (acc) begin
                  op_sec  <= sec_i;
                  op_byte <= byte_i;
                  op_data <= din_i;
                  cnt     <= '0;
                  st      <= prot_i[sec_i] ? S_IDLE : S_PROG;
                end
        S_ECNF: if (acc) begin
                  op_sec  <= sec_i;
                  op_byte <= '0;
                  cnt     <= '0;
                  st      <= (din_i == CMD_CONF && !prot_i[sec_i]) ? S_PRE : S_IDLE;
                end
        S_PROG: if (cnt == CNT_W'(PROG_CYC - 1)) begin
                  prog_exp <= op_data & mem_rdata_i;
                  cnt      <= '0;
                  st       <= S_PVER;
                end else cnt <= cnt + 1'b1;
        S_PVER: st <= (mem_rdata_i == prog_exp) ? S_IDLE : S_PROG;
        S_PRE:  if (mem_rdata_i == 8'h00 || cnt == CNT_W'(PRE_CYC - 1)) begin
                  cnt     <= '0;
                  op_byte <= op_byte + 1'b1;
                  if (last_byte) st <= S_ERASE;
                end else cnt <= cnt + 1'b1;
        S_ERASE: if (cnt == CNT_W'(ERASE_CYC - 1)) begin
                   cnt <= '0;
                   st  <= S_FILL;
                 end else cnt <= cnt + 1'b1;
        S_FILL: begin
                  op_byte <= op_byte + 1'b1;
                  if (last_byte) st <= S_EVER;
                end
        S_EVER: if (mem_rdata_i != 8'hFF) begin
                  op_byte <= '0;
                  st      <= S_ERASE;
                end else begin
                  op_byte <= op_byte + 1'b1;
                  if (last_byte) st <= S_IDLE;
                end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  tog <= 1'b0;
    else if (rd_evt_i && busy_o)  tog <= ~tog;
  end

  assign stat_o = {erasing ? 1'b0 : ~op_data[7], tog, 6'b0};

  // R2
  idle_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_we_o);
  // R10
  low_vcc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_vcc_i && !busy_o) |=> st == $past(st));
  // R9
  prot_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st == S_PARG || st == S_ECNF) && acc && prot_i[sec_i]) |=> st == S_IDLE);
  // R8
  erase_after_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_ERASE && $past(st) != S_ERASE) |->
      ($past(st) == S_PRE || $past(st) == S_EVER));
  // R6
  prog_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st == S_PROG |-> cnt < CNT_W'(PROG_CYC));
endmodule

// File: rtl/flash_ctrl.sv
module flash_ctrl #(
  parameter int ADDR_W    = 17,
  parameter int SEC_W     = 3,
  parameter int BYTE_AW   = 8,
  parameter int PROG_CYC  = 8,
  parameter int PRE_CYC   = 2,
  parameter int ERASE_CYC = 20,
  localparam int IDX_W    = SEC_W + BYTE_AW,
  localparam int NSEC     = 1 << SEC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        dq_i,
  output logic [7:0]        dq_o,
  output logic              dq_oe_o,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              low_vcc_i,
  input  logic [NSEC-1:0]   prot_i
);
  logic               wr_evt, rd_evt, busy, mem_we;
  logic [IDX_W-1:0]   alg_addr;
  logic [7:0]         alg_rdata, host_rdata, mem_wdata, stat;
  logic [SEC_W-1:0]   sec;
  logic [BYTE_AW-1:0] byte_idx;

  assign sec      = addr_i[ADDR_W-1 -: SEC_W];
  assign byte_idx = addr_i[BYTE_AW-1:0];

  generate
    if (ADDR_W - SEC_W > BYTE_AW) begin : g_alias
      logic unused_mid;
      assign unused_mid = ^addr_i[ADDR_W-SEC_W-1:BYTE_AW];
    end
  endgenerate

  flash_bus_sync u_bus (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni,
    .wr_evt_o(wr_evt), .rd_evt_o(rd_evt)
  );

  flash_cmd_fsm #(
    .SEC_W(SEC_W), .BYTE_AW(BYTE_AW), .PROG_CYC(PROG_CYC),
    .PRE_CYC(PRE_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_fsm (
    .clk_i, .rst_ni,
    .wr_evt_i(wr_evt), .rd_evt_i(rd_evt),
    .sec_i(sec), .byte_i(byte_idx), .din_i(dq_i),
    .low_vcc_i, .prot_i,
    .mem_rdata_i(alg_rdata), .mem_we_o(mem_we), .mem_addr_o(alg_addr),
    .mem_wdata_o(mem_wdata), .busy_o(busy), .stat_o(stat)
  );

  flash_array #(.SEC_W(SEC_W), .BYTE_AW(BYTE_AW)) u_arr (
    .clk_i, .rst_ni,
    .we_i(mem_we), .waddr_i(alg_addr), .wdata_i(mem_wdata),
    .host_raddr_i({sec, byte_idx}), .host_rdata_o(host_rdata),
    .alg_raddr_i(alg_addr), .alg_rdata_o(alg_rdata)
  );

  assign dq_o    = busy ? stat : host_rdata;
  assign dq_oe_o = !ce_ni && !oe_ni;

  // R1
  bus_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni) |-> !dq_oe_o);
endmodule

// File: tb/flash_ctrl_tb.sv
module flash_ctrl_tb;
  localparam int PROG_CYC  = 8;
  localparam int PRE_CYC   = 2;
  localparam int ERASE_CYC = 20;
  localparam int SEC_BYTES = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dq;
  logic        dq_oe;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic        low_vcc = 1'b0;
  logic [7:0]  prot = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_ctrl #(.PROG_CYC(PROG_CYC), .PRE_CYC(PRE_CYC), .ERASE_CYC(ERASE_CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .dq_i(din), .dq_o(dq),
    .dq_oe_o(dq_oe), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .low_vcc_i(low_vcc), .prot_i(prot)
  );

  // {address, program value, expected byte}
  localparam logic [32:0] VEC [6] = '{
    {17'h00010, 8'hA5, 8'hA5},
    {17'h00010, 8'h3C, 8'h24},
    {17'h04020, 8'h00, 8'h00},
    {17'h1FFFF, 8'h7E, 8'h7E},
    {17'h0C0FF, 8'h81, 8'h81},
    {17'h00011, 8'hFF, 8'hFF}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; addr = a; din = d; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic rd(input logic [16:0] a, output logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk); d = dq; oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic prog(input logic [16:0] a, input logic [7:0] d);
    wr(17'h0, 8'h5A); wr(17'h0, 8'h3C); wr(a, d);
  endtask

  task automatic erase(input logic [16:0] a, input logic [7:0] conf);
    wr(17'h0, 8'h5A); wr(17'h0, 8'hC3); wr(a, conf);
  endtask

  task automatic wait_done(input logic [16:0] a, output logic [7:0] d, output int el);
    logic [7:0] prev, cur;
    int t0 = cyc;
    rd(a, prev);
    for (int k = 0; k < 4000; k++) begin
      rd(a, cur);
      if (cur == prev) break;
      prev = cur;
    end
    d = cur; el = cyc - t0;
  endtask

  task automatic rd_stable(input string req, input logic [16:0] a, input logic [7:0] exp);
    logic [7:0] r1, r2;
    rd(a, r1); rd(a, r2);
    chk(req, r1, exp);
    chk(req, r2, exp);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, r1, r2;
    int el;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 bus drive
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; #1 chk("R1 ce only", dq_oe, 0);
    ce_n = 1'b1; oe_n = 1'b0; #1 chk("R1 oe only", dq_oe, 0);
    ce_n = 1'b0; oe_n = 1'b0; #1 chk("R1 both", dq_oe, 1);
    ce_n = 1'b1; oe_n = 1'b1; #1 chk("R1 idle", dq_oe, 0);

    // R2 reset contents
    rd(17'h00000, v); chk("R2 reset byte", v, 8'hFF);
    rd(17'h1ABCD, v); chk("R2 reset byte hi", v, 8'hFF);

    // R3 program vectors
    foreach (VEC[i]) begin
      prog(VEC[i][32:16], VEC[i][15:8]);
      wait_done(VEC[i][32:16], v, el);
      chk("R3 programmed byte", v, VEC[i][7:0]);
      chk("R6 program done in time", int'(el <= PROG_CYC + 8), 1);
    end

    // R4 R5 R6 status while programming
    prog(17'h08005, 8'h0F);
    rd(17'h08005, r1); rd(17'h08005, r2);
    chk("R4 prog dq7 complement", r1[7], 1);
    chk("R4 low status bits", r1[5:0], 0);
    chk("R5 toggle inverts", int'(r1[6] != r2[6]), 1);
    repeat (PROG_CYC + 2) @(negedge clk);
    rd_stable("R6 array after program", 17'h08005, 8'h0F);

    // R9 protection
    prot = 8'h02;
    prog(17'h04021, 8'h00);
    rd_stable("R9 protected program", 17'h04021, 8'hFF);
    erase(17'h04000, 8'h96);
    rd_stable("R9 protected erase", 17'h04020, 8'h00);
    prot = 8'h00;

    // R10 low supply
    low_vcc = 1'b1;
    prog(17'h00020, 8'h00);
    low_vcc = 1'b0;
    rd_stable("R10 low supply inhibit", 17'h00020, 8'hFF);

    // R11 bad sequences
    wr(17'h0, 8'h5A); wr(17'h0, 8'h11); wr(17'h00030, 8'h00);
    rd_stable("R11 bad opcode", 17'h00030, 8'hFF);
    erase(17'h00000, 8'h77);
    rd_stable("R11 bad confirm", 17'h00010, 8'h24);

    // R7 R8 erase sector 0
    erase(17'h00000, 8'h96);
    rd(17'h00010, r1);
    chk("R4 erase dq7 low", r1[7], 0);
    wait_done(17'h00010, v, el);
    chk("R7 erased byte", v, 8'hFF);
    chk("R8 preprogram time", int'(el >= SEC_BYTES * PRE_CYC + ERASE_CYC), 1);
    rd(17'h00011, v); chk("R7 erased byte 2", v, 8'hFF);
    rd(17'h04020, v); chk("R7 other sector kept", v, 8'h00);
    rd(17'h1FFFF, v); chk("R7 other sector kept hi", v, 8'h7E);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule